// File: doc/BRIEF.md
# Output-Port Cell Resequencer

This block sits at an output port of a two-stage load-balanced switch. Cells of one flow are spread across the intermediate ports, and different intermediate ports can delay them by different amounts, so they can arrive out of order. Each arriving cell carries the index of the intermediate port it came through, the identifier of its source flow, a sequence number and a payload. The cell is appended to a FIFO owned by that intermediate port. There is one FIFO per intermediate port, each `NUM_PORTS` cells deep, so the total storage is `NUM_PORTS*NUM_PORTS` cells.

In every cycle the block looks only at the head cell of each FIFO. A head cell is eligible when its sequence number equals the sequence number the block expects next for that cell's flow. One eligible head is offered on the output with a valid/ready handshake. When several heads are eligible, a rotating pointer chooses among them. When a cell departs, the expected sequence number of its flow advances by one. Flows therefore leave in their original order.

If a cell arrives when the storage is full, or when its own FIFO is full, the cell is discarded and a one-cycle error flag is raised.

Top module: `rsq_resequencer`

## Requirements
- R1: After reset all FIFOs are empty, every flow expects sequence number 0, the round-robin pointer is 0, and `outValid` and `overflowErr` are low.
- R2: An accepted cell (`inValid` high, not discarded) is appended to the FIFO selected by `inPort`. It can appear on the output in the cycle after the clock edge that stores it, and not earlier.
- R3: A cell is offered only when it is at the head of its FIFO and its sequence number equals its flow's expected value. A cell that is not eligible also blocks every cell behind it in the same FIFO.
- R4: When a cell of flow f departs, flow f's expected sequence number increments by one, modulo 2^`SEQ_W` (so 7 is followed by 0 when `SEQ_W`=3).
- R5: At most one cell departs per cycle, and only on a cycle with `outValid` and `outReady` both high. While `outReady` is low, no cell is removed and `outValid` stays high.
- R6: Among the eligible heads, the block offers the first one found when scanning FIFO indices upward (with wrap) from the round-robin pointer. After a departure from FIFO i, the pointer becomes (i+1) mod `NUM_PORTS`.
- R7: An arriving cell is discarded if the total occupancy equals `NUM_PORTS*NUM_PORTS` or its target FIFO already holds `NUM_PORTS` cells. `overflowErr` is high in the cycle after each discarded arrival and is low otherwise.
- R8: On the output, the cells of each flow carry consecutive sequence numbers, modulo 2^`SEQ_W`, starting from 0.
- R9: `outPort`, `outFlow`, `outSeq` and `outData` show the FIFO index and the stored fields of the offered cell. The stored cell is packed as {flow, seq, data}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Arriving cell present |
| inPort | input | $clog2(NUM_PORTS) | Intermediate port the cell came through |
| inFlow | input | FLOW_W | Source flow identifier |
| inSeq | input | SEQ_W | Per-flow sequence number |
| inData | input | DATA_W | Cell payload |
| outReady | input | 1 | Downstream accepts a cell this cycle |
| outValid | output | 1 | An in-order cell is offered |
| outPort | output | $clog2(NUM_PORTS) | FIFO index of the offered cell |
| outFlow | output | FLOW_W | Flow of the offered cell |
| outSeq | output | SEQ_W | Sequence number of the offered cell |
| outData | output | DATA_W | Payload of the offered cell |
| overflowErr | output | 1 | An arrival was discarded in the previous cycle |

## Verification
The bench builds the block with four intermediate ports, four flows, 3-bit sequence numbers and 8-bit payloads. With these values each FIFO holds only four cells and the whole storage holds sixteen, so a short burst reaches both the per-FIFO limit and the total limit. The 3-bit sequence field also wraps after only eight cells of one flow. Four FIFOs are enough for head-of-line blocking and for several heads to compete under the rotating pointer at the same time.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  // Strobes from control to datapath, one per storage operation.
  typedef struct packed {
    logic push;
    logic pop;
  } rsqStrobe_t;

endpackage

// File: rtl/rsq_datapath.sv
module rsq_datapath
  import rsq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int FLOW_W    = 2,
  parameter int SEQ_W     = 3,
  parameter int DATA_W    = 8
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  rsqStrobe_t                          strb,
  input  logic [$clog2(NUM_PORTS)-1:0]        pushIdx,
  input  logic [FLOW_W+SEQ_W+DATA_W-1:0]      pushCell,
  input  logic [$clog2(NUM_PORTS)-1:0]        popIdx,
  output logic [NUM_PORTS-1:0]                headValid,
  output logic [NUM_PORTS-1:0][FLOW_W-1:0]    headFlow,
  output logic [NUM_PORTS-1:0][SEQ_W-1:0]     headSeq,
  output logic [NUM_PORTS-1:0]                qFull,
  output logic [$clog2(NUM_PORTS*NUM_PORTS+1)-1:0] totalCnt,
  output logic [FLOW_W+SEQ_W+DATA_W-1:0]      selCell
);

  localparam int DEPTH  = NUM_PORTS;
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int CELL_W = FLOW_W + SEQ_W + DATA_W;

  logic [NUM_PORTS-1:0][CELL_W-1:0] headCell;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar q = 0; q < NUM_PORTS; q++) begin : g_queue
    logic [CELL_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wrPtr;
    logic [PTR_W-1:0]  rdPtr;
    logic [CNT_W-1:0]  cnt;
    logic              doPush;
    logic              doPop;

    assign doPush = strb.push && (pushIdx == ($clog2(NUM_PORTS))'(q));
    assign doPop  = strb.pop  && (popIdx  == ($clog2(NUM_PORTS))'(q));

    always_ff @(posedge clk) begin
      if (doPush) mem[wrPtr] <= pushCell;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        cnt   <= '0;
      end else begin
        if (doPush) wrPtr <= nextPtr(wrPtr);
        if (doPop)  rdPtr <= nextPtr(rdPtr);
        case ({doPush, doPop})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end

    assign headCell[q]  = mem[rdPtr];
    assign headValid[q] = (cnt != '0);
    assign qFull[q]     = (cnt == CNT_W'(DEPTH));
    assign headFlow[q]  = headCell[q][CELL_W-1 -: FLOW_W];
    assign headSeq[q]   = headCell[q][DATA_W +: SEQ_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      totalCnt <= '0;
    end else begin
      case ({strb.push, strb.pop})
        2'b10:   totalCnt <= totalCnt + 1'b1;
        2'b01:   totalCnt <= totalCnt - 1'b1;
        default: totalCnt <= totalCnt;
      endcase
    end
  end

  assign selCell = headCell[popIdx];

endmodule

// File: rtl/rsq_control.sv
module rsq_control
  import rsq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int FLOW_W    = 2,
  parameter int SEQ_W     = 3
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                inValid,
  input  logic [$clog2(NUM_PORTS)-1:0]        inPort,
  input  logic [NUM_PORTS-1:0]                headValid,
  input  logic [NUM_PORTS-1:0][FLOW_W-1:0]    headFlow,
  input  logic [NUM_PORTS-1:0][SEQ_W-1:0]     headSeq,
  input  logic [NUM_PORTS-1:0]                qFull,
  input  logic [$clog2(NUM_PORTS*NUM_PORTS+1)-1:0] totalCnt,
  input  logic                                outReady,
  output rsqStrobe_t                          strb,
  output logic [$clog2(NUM_PORTS)-1:0]        popIdx,
  output logic                                outValid,
  output logic                                overflowErr
);

  localparam int PORT_W    = $clog2(NUM_PORTS);
  localparam int NUM_FLOWS = 1 << FLOW_W;
  localparam int TOTAL     = NUM_PORTS * NUM_PORTS;
  localparam int TOT_W     = $clog2(TOTAL + 1);

  logic [SEQ_W-1:0]     expSeq [NUM_FLOWS];
  logic [PORT_W-1:0]    rrPtr;
  logic [NUM_PORTS-1:0] eligible;
  logic                 found;
  logic                 blocked;

  for (genvar q = 0; q < NUM_PORTS; q++) begin : g_elig
    assign eligible[q] = headValid[q] && (headSeq[q] == expSeq[headFlow[q]]);
  end

  // Rotating scan: first eligible head at or after the pointer.
  always_comb begin
    found  = 1'b0;
    popIdx = '0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      int idx;
      idx = int'(rrPtr) + k;
      if (idx >= NUM_PORTS) idx = idx - NUM_PORTS;
      if (!found && eligible[idx]) begin
        found  = 1'b1;
        popIdx = PORT_W'(idx);
      end
    end
  end

  assign blocked   = (totalCnt == TOT_W'(TOTAL)) || qFull[inPort];
  assign outValid  = found;
  assign strb.pop  = found && outReady;
  assign strb.push = inValid && !blocked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr       <= '0;
      overflowErr <= 1'b0;
      for (int f = 0; f < NUM_FLOWS; f++) expSeq[f] <= '0;
    end else begin
      overflowErr <= inValid && blocked;
      if (strb.pop) begin
        rrPtr <= (popIdx == PORT_W'(NUM_PORTS - 1)) ? '0 : popIdx + 1'b1;
        expSeq[headFlow[popIdx]] <= expSeq[headFlow[popIdx]] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rsq_resequencer.sv
module rsq_resequencer
  import rsq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int FLOW_W    = 2,
  parameter int SEQ_W     = 3,
  parameter int DATA_W    = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic [$clog2(NUM_PORTS)-1:0] inPort,
  input  logic [FLOW_W-1:0]            inFlow,
  input  logic [SEQ_W-1:0]             inSeq,
  input  logic [DATA_W-1:0]            inData,
  input  logic                         outReady,
  output logic                         outValid,
  output logic [$clog2(NUM_PORTS)-1:0] outPort,
  output logic [FLOW_W-1:0]            outFlow,
  output logic [SEQ_W-1:0]             outSeq,
  output logic [DATA_W-1:0]            outData,
  output logic                         overflowErr
);

  localparam int PORT_W = $clog2(NUM_PORTS);
  localparam int CELL_W = FLOW_W + SEQ_W + DATA_W;
  localparam int TOT_W  = $clog2(NUM_PORTS * NUM_PORTS + 1);

  rsqStrobe_t                       strb;
  logic [PORT_W-1:0]                popIdx;
  logic [NUM_PORTS-1:0]             headValid;
  logic [NUM_PORTS-1:0][FLOW_W-1:0] headFlow;
  logic [NUM_PORTS-1:0][SEQ_W-1:0]  headSeq;
  logic [NUM_PORTS-1:0]             qFull;
  logic [TOT_W-1:0]                 totalCnt;
  logic [CELL_W-1:0]                selCell;

  rsq_control #(
    .NUM_PORTS(NUM_PORTS), .FLOW_W(FLOW_W), .SEQ_W(SEQ_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPort(inPort),
    .headValid(headValid), .headFlow(headFlow), .headSeq(headSeq),
    .qFull(qFull), .totalCnt(totalCnt), .outReady(outReady),
    .strb(strb), .popIdx(popIdx), .outValid(outValid),
    .overflowErr(overflowErr)
  );

  rsq_datapath #(
    .NUM_PORTS(NUM_PORTS), .FLOW_W(FLOW_W), .SEQ_W(SEQ_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pushIdx(inPort),
    .pushCell({inFlow, inSeq, inData}), .popIdx(popIdx),
    .headValid(headValid), .headFlow(headFlow), .headSeq(headSeq),
    .qFull(qFull), .totalCnt(totalCnt), .selCell(selCell)
  );

  assign outPort = popIdx;
  assign outFlow = selCell[CELL_W-1 -: FLOW_W];
  assign outSeq  = selCell[DATA_W +: SEQ_W];
  assign outData = selCell[DATA_W-1:0];

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int NUM_PORTS = 4,
  parameter int FLOW_W    = 2,
  parameter int SEQ_W     = 3
) (
  input logic                                     clk,
  input logic                                     rstN,
  input logic                                     inValid,
  input logic                                     outValid,
  input logic                                     outReady,
  input logic [FLOW_W-1:0]                        outFlow,
  input logic [SEQ_W-1:0]                         outSeq,
  input logic                                     overflowErr,
  input logic [$clog2(NUM_PORTS*NUM_PORTS+1)-1:0] totalCnt
);

  localparam int NUM_FLOWS = 1 << FLOW_W;
  localparam int TOTAL     = NUM_PORTS * NUM_PORTS;

  logic [SEQ_W-1:0] seenNext [NUM_FLOWS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int f = 0; f < NUM_FLOWS; f++) seenNext[f] <= '0;
    end else if (outValid && outReady) begin
      seenNext[outFlow] <= outSeq + 1'b1;
    end
  end

  // R1: output idle on the first cycle out of reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && !overflowErr));

  // R5: a stalled offer remains offered
  a_r5_stall_keeps_valid: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R7: an error flag always follows an arrival
  a_r7_err_follows_arrival: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |-> $past(inValid));

  // R7: occupancy never exceeds the storage
  a_r7_occupancy_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(totalCnt) <= TOTAL);

  // R8: departures of each flow are consecutive
  a_r8_flow_in_order: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |-> (outSeq == seenNext[outFlow]));

endmodule

bind rsq_resequencer rsq_checker #(
  .NUM_PORTS(NUM_PORTS), .FLOW_W(FLOW_W), .SEQ_W(SEQ_W)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .outReady(outReady), .outFlow(outFlow), .outSeq(outSeq),
  .overflowErr(overflowErr), .totalCnt(totalCnt)
);

// File: tb/rsq_resequencer_bench.sv
module rsq_resequencer_bench;

  localparam int NP = 4;
  localparam int FW = 2;
  localparam int SW = 3;
  localparam int DW = 8;
  localparam int PW = $clog2(NP);
  localparam int NF = 1 << FW;
  localparam int NS = 1 << SW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [PW-1:0] inPort = '0;
  logic [FW-1:0] inFlow = '0;
  logic [SW-1:0] inSeq = '0;
  logic [DW-1:0] inData = '0;
  logic outReady = 1'b0;
  logic outValid;
  logic [PW-1:0] outPort;
  logic [FW-1:0] outFlow;
  logic [SW-1:0] outSeq;
  logic [DW-1:0] outData;
  logic overflowErr;

  always #5 clk = ~clk;

  rsq_resequencer #(.NUM_PORTS(NP), .FLOW_W(FW), .SEQ_W(SW), .DATA_W(DW)) u_rsq_resequencer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPort(inPort), .inFlow(inFlow),
    .inSeq(inSeq), .inData(inData), .outReady(outReady), .outValid(outValid),
    .outPort(outPort), .outFlow(outFlow), .outSeq(outSeq), .outData(outData),
    .overflowErr(overflowErr)
  );

  // Behavioural reference state
  int mq [NP][$];
  int expS [NF];
  int nextSend [NF];
  int rr;
  int tot;
  bit errExp;
  int vecs = 0;
  int bad = 0;
  bit done = 0;

  function automatic int cFlow(int c); return (c >> (SW + DW)) % NF; endfunction
  function automatic int cSeq(int c);  return (c >> DW) % NS; endfunction
  function automatic int cData(int c); return c % (1 << DW); endfunction

  function automatic int pick();
    for (int k = 0; k < NP; k++) begin
      int idx = (rr + k) % NP;
      if (mq[idx].size() > 0)
        if (cSeq(mq[idx][0]) == expS[cFlow(mq[idx][0])]) return idx;
    end
    return -1;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int q = 0; q < NP; q++) mq[q].delete();
    for (int f = 0; f < NF; f++) begin expS[f] = 0; nextSend[f] = 0; end
    rr = 0; tot = 0; errExp = 0;
  endtask

  task automatic cyc(input bit v, input int p, input int f, input int s, input int d,
                     input bit rdy, input string tag);
    int sel;
    bit blk;
    inValid = v; inPort = PW'(p); inFlow = FW'(f); inSeq = SW'(s); inData = DW'(d);
    outReady = rdy;
    #1;
    sel = pick();
    check(tag, "outValid", int'(outValid), (sel >= 0) ? 1 : 0);
    if (sel >= 0) begin
      check("R9", "outPort", int'(outPort), sel);
      check("R9", "outFlow", int'(outFlow), cFlow(mq[sel][0]));
      check("R9", "outSeq",  int'(outSeq),  cSeq(mq[sel][0]));
      check("R9", "outData", int'(outData), cData(mq[sel][0]));
    end
    check("R7", "overflowErr", int'(overflowErr), int'(errExp));
    @(posedge clk);
    blk = (tot == NP * NP) || (mq[p].size() == NP);
    errExp = v && blk;
    if (sel >= 0 && rdy) begin
      int c = mq[sel].pop_front();
      expS[cFlow(c)] = (expS[cFlow(c)] + 1) % NS;
      rr = (sel + 1) % NP;
      tot--;
    end
    if (v && !blk) begin
      mq[p].push_back((f << (SW + DW)) | (s << DW) | d);
      tot++;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit rdy, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, rdy, tag);
  endtask

  // Send the next in-order cell of flow f through port p.
  task automatic send(input int f, input int p, input bit rdy, input string tag);
    cyc(1, p, f, nextSend[f], $urandom_range(0, 255), rdy, tag);
    nextSend[f] = (nextSend[f] + 1) % NS;
  endtask

  task automatic doReset();
    inValid = 0; outReady = 0; rstN = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rstN = 1;
    modelReset();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: idle state after reset
    idle(3, 1, "R1");

    // R2: in-order cells across all ports depart a cycle after arrival
    for (int i = 0; i < 4; i++) send(0, i, 1, "R2");
    idle(2, 1, "R2");

    // R3: seq 1 arrives before seq 0 and must wait
    cyc(1, 1, 1, 1, 8'hA1, 1, "R3");
    idle(2, 1, "R3");
    cyc(1, 2, 1, 0, 8'hA0, 1, "R3");
    idle(3, 1, "R3");
    nextSend[1] = 2;

    // R3: head-of-line blocking inside one FIFO
    cyc(1, 0, 2, 1, 8'hB1, 1, "R3");
    cyc(1, 0, 3, 0, 8'hC0, 1, "R3");
    idle(2, 1, "R3");
    cyc(1, 1, 2, 0, 8'hB0, 1, "R3");
    idle(4, 1, "R3");
    nextSend[2] = 2; nextSend[3] = 1;

    // R5: stall with outReady low
    send(0, 3, 0, "R5");
    idle(3, 0, "R5");
    idle(2, 1, "R5");

    // R6: several eligible heads compete under the rotating pointer
    send(1, 0, 0, "R6");
    send(2, 1, 0, "R6");
    send(3, 2, 0, "R6");
    send(0, 3, 0, "R6");
    idle(6, 1, "R6");

    // R4: wrap of the sequence number on one flow
    for (int i = 0; i < 12; i++) send(1, i % NP, 1, "R4");
    idle(3, 1, "R4");

    // R7: single FIFO overflow
    doReset();
    for (int i = 0; i < NP; i++) cyc(1, 0, 3, 5, i, 0, "R7");
    cyc(1, 0, 3, 5, 99, 0, "R7");
    idle(2, 0, "R7");
    // R7: total storage full
    for (int q = 1; q < NP; q++)
      for (int i = 0; i < NP; i++) cyc(1, q, 3, 5, i, 0, "R7");
    cyc(1, 2, 0, 0, 7, 1, "R7");
    cyc(1, 1, 0, 0, 7, 1, "R7");
    idle(2, 1, "R7");

    // R8: random in-order-per-flow traffic with random backpressure
    doReset();
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom_range(0, 99) < 35);
      bit r = ($urandom_range(0, 99) < 75);
      if (v) send($urandom_range(0, NF - 1), $urandom_range(0, NP - 1), r, "R8");
      else   cyc(0, 0, 0, 0, 0, r, "R8");
    end
    idle(20, 1, "R8");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule